// File: doc/BRIEF.md
# Iterative Feistel Lightweight Block Cipher Core

This block encrypts or decrypts one n-bit block under an n-bit key. It uses a balanced Feistel network that finishes one round per clock. The datapath is built only from word-wise addition modulo 2^b, XOR, rotation of words and bits, and a 3-bit S-box. The S-box is applied bitsliced across groups of three words. The default size is n = 48 and b = 8, so each half holds three 8-bit words. The default round count is 3n/4 + 2 = 38.

A host presents the key and the text, selects the direction, and pulses the start input for one cycle. Round keys are not stored. A key schedule that runs beside the data rounds derives each one during the round that uses it. The key sequence is symmetric about its midpoint, so encryption and decryption both walk the same schedule forwards and share all of the hardware.

The block rejects configurations it cannot build at elaboration. It requires n to be a multiple of 6b and the round count to be even and at least 2.

Top module: `fstl_cipher`

## Requirements
- R1: Text and key bits [n-1:n/2] form the left half and bits [n/2-1:0] form the right half. Word j of a half occupies bits [j*b+b-1 : j*b]. An encrypt round maps (L, R) to (R, Wrot(L) XOR F(R, K)). Word j of Wrot(L) is word (j+1) mod (n/2b) of L.
- R2: F(x, K) first adds K to x word by word, modulo 2^b. It then applies the S-box to each group of words 3g, 3g+1 and 3g+2. For each bit i, the group forms v = {w2[i], w1[i], w0[i]} and replaces it with table[v], where table = {0,5,6,7,4,3,1,2} indexed 0 to 7. Last, each word whose index mod 3 is 1 is rotated left one bit, each word whose index mod 3 is 2 is rotated right one bit, and the remaining words are unchanged.
- R3: A decrypt round maps (L, R) to (Wrot⁻¹(R XOR F(L, K)), L).
- R4: The key state starts as the key. For r < nr/2, forward key round r maps (KL, KR) to (KR, KL XOR F(KR, C)), where C holds r+1 in word 0 and zero in every other word. The round key for data round r is the right half of the state after r forward key rounds. Data round nr-1-r uses that same key. In hardware the key halves swap at the midpoint and the schedule then runs back down.
- R5: Decrypting a ciphertext with the key that produced it returns the original plaintext.
- R6: done_o rises for exactly one cycle, nr clock edges after the edge that accepts start_i. At that point result_o holds the output of the final round.
- R7: A start_i pulse while a block is in flight is ignored. It changes neither the result, nor the direction, nor the round count, and it produces no extra done_o pulse.
- R8: Reset clears result_o and done_o. When idle, result_o holds its value until the next accepted start_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a block; sampled only while idle |
| decrypt_i | input | 1 | 1 selects decryption, 0 encryption; sampled with start_i |
| key_i | input | N | Cipher key, sampled with start_i |
| text_i | input | N | Plaintext or ciphertext, sampled with start_i |
| result_o | output | N | Final-round state; valid when done_o is high |
| done_o | output | 1 | One-cycle pulse when the final round is complete |

## Verification
The assertions assume that key_i, text_i and decrypt_i matter only in the cycle start_i is accepted. They also assume the block is in reset before the first edge. The stimulus changes those inputs freely around each start, including mid-run, and releases reset only after several idle cycles. The mid-run start pulse deliberately carries a different key, text and direction, so any leak into the in-flight block would change its result. Checking the round-trip over random key and text pairs, together with the reference model, exercises both branches of the shared datapath and both phases of the key schedule.

// File: rtl/fstl_pkg.sv
package fstl_pkg;
  // 3-bit substitution, input {w2,w1,w0}
  function automatic logic [2:0] sbox3(input logic [2:0] v);
    case (v)
      3'd0: sbox3 = 3'd0;
      3'd1: sbox3 = 3'd5;
      3'd2: sbox3 = 3'd6;
      3'd3: sbox3 = 3'd7;
      3'd4: sbox3 = 3'd4;
      3'd5: sbox3 = 3'd3;
      3'd6: sbox3 = 3'd1;
      default: sbox3 = 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/fstl_round_f.sv
module fstl_round_f #(
  parameter int B  = 8,
  parameter int NB = 3
) (
  input  logic [NB*B-1:0] x_i,
  input  logic [NB*B-1:0] k_i,
  output logic [NB*B-1:0] y_o
);
  localparam int NG = NB / 3;

  logic [NB*B-1:0] sum;
  logic [NB*B-1:0] sub;

  for (genvar j = 0; j < NB; j++) begin : g_add
    assign sum[j*B +: B] = x_i[j*B +: B] + k_i[j*B +: B];
  end

  // R2 bitsliced S-box over word triples
  for (genvar g = 0; g < NG; g++) begin : g_grp
    for (genvar i = 0; i < B; i++) begin : g_bit
      logic [2:0] v;
      logic [2:0] o;
      assign v = {sum[(3*g+2)*B+i], sum[(3*g+1)*B+i], sum[3*g*B+i]};
      assign o = fstl_pkg::sbox3(v);
      assign sub[3*g*B+i]     = o[0];
      assign sub[(3*g+1)*B+i] = o[1];
      assign sub[(3*g+2)*B+i] = o[2];
    end
  end

  for (genvar j = 0; j < NB; j++) begin : g_rot
    logic [B-1:0] w;
    assign w = sub[j*B +: B];
    if (j % 3 == 1) begin : g_left
      assign y_o[j*B +: B] = {w[B-2:0], w[B-1]};
    end else if (j % 3 == 2) begin : g_right
      assign y_o[j*B +: B] = {w[0], w[B-1:1]};
    end else begin : g_keep
      assign y_o[j*B +: B] = w;
    end
  end
endmodule

// File: rtl/fstl_key_sched.sv
module fstl_key_sched #(
  parameter int N  = 48,
  parameter int B  = 8,
  parameter int NR = 38
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  adv_i,
  input  logic [N-1:0]          key_i,
  input  logic [$clog2(NR)-1:0] rnd_i,
  output logic [N/2-1:0]        rkey_o
);
  localparam int HALF = N / 2;
  localparam int NB   = HALF / B;
  localparam int CW   = $clog2(NR);
  localparam logic [CW-1:0] HN_C   = CW'(NR / 2);
  localparam logic [CW-1:0] HM_C   = CW'(NR / 2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(NR - 1);

  logic [HALF-1:0] ks_l, ks_r, cvec, fk;
  logic [CW-1:0]   cval;

  // forward constants rise to the midpoint, then fall back
  always_comb begin
    cval = (rnd_i < HN_C) ? rnd_i + 1'b1 : LAST_C - rnd_i;
    cvec = '0;
    cvec[B-1:0] = B'(cval);
  end

  fstl_round_f #(.B(B), .NB(NB)) u_fk (
    .x_i(ks_r),
    .k_i(cvec),
    .y_o(fk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ks_l <= '0;
      ks_r <= '0;
    end else if (load_i) begin
      ks_l <= key_i[N-1:HALF];
      ks_r <= key_i[HALF-1:0];
    end else if (adv_i) begin
      if (rnd_i == HM_C) begin
        ks_l <= ks_r;
        ks_r <= ks_l;
      end else begin
        ks_l <= ks_r;
        ks_r <= ks_l ^ fk;
      end
    end
  end

  // R4 second half reads the swapped state from the left
  assign rkey_o = (rnd_i < HN_C) ? ks_r : ks_l;

  // R4
  mid_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && rnd_i == HM_C) |=> (ks_l == $past(ks_r)) && (ks_r == $past(ks_l)));
endmodule

// File: rtl/fstl_cipher.sv
module fstl_cipher #(
  parameter int N  = 48,
  parameter int B  = 8,
  parameter int NR = 3 * N / 4 + 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         decrypt_i,
  input  logic [N-1:0] key_i,
  input  logic [N-1:0] text_i,
  output logic [N-1:0] result_o,
  output logic         done_o
);
  localparam int HALF = N / 2;
  localparam int NB   = HALF / B;
  localparam int CW   = $clog2(NR);
  localparam logic [CW-1:0] LAST_C = CW'(NR - 1);

  if ((N % (6 * B)) != 0 || (NR % 2) != 0 || NR < 2) begin : g_bad_cfg
    $error("fstl_cipher: N must be a multiple of 6*B and NR even and >= 2");
  end

  logic            busy_q, dec_q, done_q;
  logic [CW-1:0]   rnd_q;
  logic [HALF-1:0] l_q, r_q;
  logic [HALF-1:0] f_in, f_out, rkey, rw_l, mix, rwi_m, nxt_l, nxt_r;
  logic            accept;

  assign accept = start_i && !busy_q;

  fstl_key_sched #(.N(N), .B(B), .NR(NR)) u_ks (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .adv_i (busy_q),
    .key_i (key_i),
    .rnd_i (rnd_q),
    .rkey_o(rkey)
  );

  // shared round function: right half on encrypt, left half on decrypt
  assign f_in = dec_q ? l_q : r_q;

  fstl_round_f #(.B(B), .NB(NB)) u_f (
    .x_i(f_in),
    .k_i(rkey),
    .y_o(f_out)
  );

  assign mix = r_q ^ f_out;

  for (genvar j = 0; j < NB; j++) begin : g_wrot
    assign rw_l[j*B +: B]  = l_q[((j + 1) % NB)*B +: B];
    assign rwi_m[j*B +: B] = mix[((j + NB - 1) % NB)*B +: B];
  end

  always_comb begin
    if (dec_q) begin
      nxt_l = rwi_m;
      nxt_r = l_q;
    end else begin
      nxt_l = r_q;
      nxt_r = rw_l ^ f_out;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      dec_q  <= 1'b0;
      done_q <= 1'b0;
      rnd_q  <= '0;
      l_q    <= '0;
      r_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        dec_q  <= decrypt_i;
        rnd_q  <= '0;
        l_q    <= text_i[N-1:HALF];
        r_q    <= text_i[HALF-1:0];
      end else if (busy_q) begin
        l_q   <= nxt_l;
        r_q   <= nxt_r;
        rnd_q <= rnd_q + 1'b1;
        if (rnd_q == LAST_C) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign result_o = {l_q, r_q};
  assign done_o   = done_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rnd_q == LAST_C) |=> (done_o && !busy_q));

  // R7
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rnd_q != LAST_C) |=> (busy_q && rnd_q == $past(rnd_q) + 1'b1 && dec_q == $past(dec_q)));

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> $stable(result_o));
endmodule

// File: tb/sim_fstl_cipher.sv
`timescale 1ns/1ps
module sim_fstl_cipher;
  localparam int N   = 48;
  localparam int B   = 8;
  localparam int NR  = 3 * N / 4 + 2;
  localparam int HW  = N / 2;
  localparam int NBW = HW / B;
  localparam logic [2:0] SBOX [8] = '{3'd0, 3'd5, 3'd6, 3'd7, 3'd4, 3'd3, 3'd1, 3'd2};

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start = 1'b0;
  logic         dec = 1'b0;
  logic [N-1:0] key = '0;
  logic [N-1:0] txt = '0;
  logic [N-1:0] result;
  logic         done;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] exp_q [$];
  string        tag_q [$];
  logic [N-1:0] last_exp = '0;

  always #2.5 clk = ~clk;

  fstl_cipher #(.N(N), .B(B), .NR(NR)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .decrypt_i(dec),
    .key_i(key), .text_i(txt), .result_o(result), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [HW-1:0] m_f(input logic [HW-1:0] x, input logic [HW-1:0] k);
    logic [HW-1:0] s, t, y;
    logic [2:0] v, o;
    logic [B-1:0] w;
    for (int j = 0; j < NBW; j++) s[j*B +: B] = x[j*B +: B] + k[j*B +: B];
    t = s;
    for (int g = 0; g < NBW / 3; g++)
      for (int i = 0; i < B; i++) begin
        v = {s[(3*g+2)*B+i], s[(3*g+1)*B+i], s[3*g*B+i]};
        o = SBOX[v];
        t[3*g*B+i] = o[0];
        t[(3*g+1)*B+i] = o[1];
        t[(3*g+2)*B+i] = o[2];
      end
    for (int j = 0; j < NBW; j++) begin
      w = t[j*B +: B];
      if (j % 3 == 1) w = {w[B-2:0], w[B-1]};
      else if (j % 3 == 2) w = {w[0], w[B-1:1]};
      y[j*B +: B] = w;
    end
    return y;
  endfunction

  function automatic logic [HW-1:0] m_rw(input logic [HW-1:0] x);
    logic [HW-1:0] y;
    for (int j = 0; j < NBW; j++) y[j*B +: B] = x[((j + 1) % NBW)*B +: B];
    return y;
  endfunction

  function automatic logic [HW-1:0] m_rwi(input logic [HW-1:0] x);
    logic [HW-1:0] y;
    for (int j = 0; j < NBW; j++) y[((j + 1) % NBW)*B +: B] = x[j*B +: B];
    return y;
  endfunction

  function automatic logic [N-1:0] m_crypt(input logic [N-1:0] k, input logic [N-1:0] x, input bit d);
    logic [HW-1:0] kl, kr, c, tmp, l, r;
    logic [HW-1:0] rk [NR];
    kl = k[N-1:HW];
    kr = k[HW-1:0];
    for (int i = 0; i < NR / 2; i++) begin
      rk[i] = kr;
      rk[NR-1-i] = kr;
      c = '0;
      c[B-1:0] = B'(i + 1);
      tmp = kl ^ m_f(kr, c);
      kl = kr;
      kr = tmp;
    end
    l = x[N-1:HW];
    r = x[HW-1:0];
    for (int i = 0; i < NR; i++) begin
      if (!d) begin
        tmp = m_rw(l) ^ m_f(r, rk[i]);
        l = r;
        r = tmp;
      end else begin
        tmp = m_rwi(r ^ m_f(l, rk[i]));
        r = l;
        l = tmp;
      end
    end
    return {l, r};
  endfunction

  // ---------------- monitor ----------------
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (prev_done && done) chk(1'b0, "R6 done wider than one cycle", {47'd0, done}, '0);
    if (done && !prev_done) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected done", result, '0);
      else begin
        logic [N-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(result === e, t, result, e);
      end
    end
    prev_done = done;
  end

  // ---------------- driver ----------------
  task automatic run(input logic [N-1:0] k, input logic [N-1:0] x, input bit d,
                     input logic [N-1:0] e, input string t);
    int cnt;
    exp_q.push_back(e);
    tag_q.push_back(t);
    last_exp = e;
    key = k; txt = x; dec = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    key = ~k; txt = ~x; dec = ~d;
    cnt = 1;
    while (!done) begin
      @(negedge clk);
      cnt++;
    end
    // R6: start edge plus NR round edges
    chk(cnt == NR + 1, "R6 latency", N'(cnt), N'(NR + 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", '0, '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] k, p, c, e;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(result === '0, "R8 reset result", result, '0);
    chk(done === 1'b0, "R8 reset done", {47'd0, done}, '0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R2 R4 fixed patterns
    run('0, '0, 1'b0, m_crypt('0, '0, 1'b0), "R1 R2 R4 zero");
    run('1, '1, 1'b0, m_crypt('1, '1, 1'b0), "R1 R2 R4 ones");
    k = 48'h0123_4567_89ab; p = 48'hfedc_ba98_7654;
    run(k, p, 1'b0, m_crypt(k, p, 1'b0), "R1 R2 R4 pattern");
    // R3 decrypt of arbitrary text
    run(k, p, 1'b1, m_crypt(k, p, 1'b1), "R3 decrypt");

    // R8 hold while idle
    repeat (10) @(negedge clk);
    chk(result === last_exp, "R8 hold", result, last_exp);

    // R7 start while busy
    k = 48'h5a5a_0f0f_3c3c; p = 48'h1111_2222_3333;
    e = m_crypt(k, p, 1'b0);
    exp_q.push_back(e);
    tag_q.push_back("R7 mid-run start ignored");
    key = k; txt = p; dec = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    key = 48'h9999_8888_7777; txt = 48'habcd_ef01_2345; dec = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(result === e, "R7 result after ignored start", result, e);

    // R5 round trips
    for (int i = 0; i < 16; i++) begin
      k = N'({$urandom(), $urandom()});
      p = N'({$urandom(), $urandom()});
      c = m_crypt(k, p, 1'b0);
      run(k, p, 1'b0, c, "R1 R4 random encrypt");
      c = result;
      run(k, c, 1'b1, p, "R5 round trip");
    end

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R7 pending results", N'(exp_q.size()), '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule